// File: doc/BRIEF.md
# Debounced Interrupt Input Controller

This block watches up to eight slow, asynchronous, input-only lines (buttons, plug detects, power signals) and turns each one into a clean interrupt source. Every line is synchronized and then filtered by its own debounce state machine. A new level is accepted only after the line has held it for a programmable number of millisecond ticks, so short glitches and contact bounce never reach software. The counting logic of a channel runs only while its synchronized input disagrees with its accepted level. It stays idle at all other times.

A shared prescaler divides the block clock into a millisecond tick. Each channel has a debounce window of 1 to 4000 ticks, an enable bit, an interrupt mask bit and a three-bit trigger type. The trigger type selects rising, falling, either edge, high level or low level. When a trigger condition occurs, the channel's pending bit is set. That bit then holds, and further events on the channel cannot add to it, until software clears it by writing a one. All masked pending bits are ORed into one registered interrupt line. Software reaches everything through a simple word-addressed register port with a single-cycle write strobe and a combinational read.

Top module: `debounce_irq_ctrl`

Each channel's debounce machine has two named states. In IDLE the counter is held at zero. The machine leaves IDLE for COUNT (transition "start") when the synchronized input differs from the accepted level. COUNT returns to IDLE in one of three ways: "abort" when the input goes back to the accepted level, "commit" on the tick after the counter has reached the window, or "disable" when the channel enable is cleared. Each channel's pending machine has the states NONE and HELD. The transition "set" moves NONE to HELD when a trigger condition occurs. The transition "clear" moves HELD to NONE on a write-one-to-clear with no trigger in the same cycle.

## Requirements
- R1: After reset, the accepted levels, pending bits, enable, mask and trigger fields are all zero, the interrupt output is low, each window field reads 1 and the prescaler field reads its reset parameter.
- R2: Each input passes a two-flop synchronizer. A new level is accepted, and shows in the accepted-level register (word 0, bit i for channel i), only when a prescaler tick occurs after the counter of an uninterrupted COUNT has reached the window. The input must therefore hold the new level across window+1 ticks.
- R3: A pulse shorter than one tick period, or a bounce that returns to the accepted level before the window completes, leaves both the accepted level and the pending bits unchanged.
- R4: The window of channel i is a 12-bit field at word 8+i. A value of 0 behaves as 1 and values above 4000 behave as 4000. The field reads back as written.
- R5: The trigger type of channel i sits in bits [3i+2:3i] of word 3, with code 0 for rising, 1 for falling, 2 for either edge, 3 for high level and 4 for low level. Codes 5 to 7 never set a pending bit. Raw pending bits read at word 4.
- R6: Once set, a pending bit stays set until a one is written to its bit position of word 6. Writing zero bits there has no effect, and word 6 reads as zero.
- R7: A level-type pending bit sets again immediately after a clear while its level is still accepted. Once the level is gone, a clear removes it.
- R8: The mask is at word 2 (1 = pass). Word 5 reads the pending bits ANDed with the mask. The interrupt output is the OR of those bits, registered, and follows them one clock later.
- R9: While a channel's enable bit (word 1) is zero, its accepted level is frozen, its counter stays idle and its pending bit cannot be set. When the enable bit is set again, filtering resumes.
- R10: The prescaler divisor D at word 7 produces one tick every D clock cycles, and D = 0 behaves as 1.
- R11: Enable, mask, trigger, prescaler and window words read back the values written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | N_CH | Raw asynchronous input lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Shared registered interrupt request |

## Verification
The bench builds the block with eight channels, 12-bit windows and a prescaler reset value of 4. It then writes a divisor of 4, so one tick lasts four cycles and the window commit, glitch rejection and bounce abort all happen within a few tens of cycles. Later it writes a divisor of 0, which gives a tick every cycle. With that setting, a window field of 4095 reaches the 4000-tick clamp within about four thousand cycles, and both the upper bound and the zero-divisor rule can be observed. A divisor of 8 with a one-tick window then checks the tick spacing against an early and a late sampling point.

// File: rtl/debounce_irq_pkg.sv
`timescale 1ns/1ps
package debounce_irq_pkg;

    // debounce machine of one channel
    typedef enum logic [0:0] {
        CH_IDLE  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_e;

    // pending-bit machine of one channel
    typedef enum logic [0:0] {
        PND_NONE = 1'b0,
        PND_HELD = 1'b1
    } pend_state_e;

    // trigger type codes
    localparam logic [2:0] TRG_RISE = 3'd0;
    localparam logic [2:0] TRG_FALL = 3'd1;
    localparam logic [2:0] TRG_BOTH = 3'd2;
    localparam logic [2:0] TRG_HIGH = 3'd3;
    localparam logic [2:0] TRG_LOW  = 3'd4;

    // register word addresses
    localparam int A_STABLE = 0;
    localparam int A_ENABLE = 1;
    localparam int A_MASK   = 2;
    localparam int A_TRIG   = 3;
    localparam int A_RAW    = 4;
    localparam int A_MSKD   = 5;
    localparam int A_CLEAR  = 6;
    localparam int A_DIV    = 7;
    localparam int A_WIN0   = 8;

endpackage

// File: rtl/dbi_tick_gen.sv
`timescale 1ns/1ps
module dbi_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    // a divisor of zero is handled like one
    assign lim = (div == '0) ? '0 : div - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= lim) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/dbi_chan.sv
`timescale 1ns/1ps
module dbi_chan
    import debounce_irq_pkg::*;
#(
    parameter int TIME_W  = 12,
    parameter int MAX_WIN = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              raw_in,
    input  logic [TIME_W-1:0] win,
    output logic              stable,
    output logic              rise,
    output logic              fall
);
    localparam logic [TIME_W-1:0] WIN_MAX = TIME_W'(MAX_WIN);
    localparam logic [TIME_W-1:0] WIN_MIN = TIME_W'(1);

    logic              sync_a, sync_b;
    ch_state_e         st_q, st_d;
    logic [TIME_W-1:0] cnt_q, cnt_d;
    logic [TIME_W-1:0] win_eff;
    logic              stable_q, stable_d;
    logic              rise_q, rise_d, fall_q, fall_d;

    assign win_eff = (win == '0)     ? WIN_MIN :
                     (win > WIN_MAX) ? WIN_MAX : win;

    // two-flop synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= raw_in;
            sync_b <= sync_a;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= CH_IDLE;
            cnt_q    <= '0;
            stable_q <= 1'b0;
            rise_q   <= 1'b0;
            fall_q   <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            stable_q <= stable_d;
            rise_q   <= rise_d;
            fall_q   <= fall_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        stable_d = stable_q;
        rise_d   = 1'b0;
        fall_d   = 1'b0;
        if (!en) begin
            st_d  = CH_IDLE;                 // disable
            cnt_d = '0;
        end else begin
            unique case (st_q)
                CH_IDLE: begin
                    cnt_d = '0;
                    if (sync_b != stable_q) begin
                        st_d = CH_COUNT;     // start
                    end
                end
                CH_COUNT: begin
                    if (sync_b == stable_q) begin
                        st_d  = CH_IDLE;     // abort
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt_q >= win_eff) begin
                            st_d     = CH_IDLE;   // commit
                            cnt_d    = '0;
                            stable_d = sync_b;
                            rise_d   = sync_b;
                            fall_d   = ~sync_b;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: st_d = CH_IDLE;
            endcase
        end
    end

    assign stable = stable_q;
    assign rise   = rise_q;
    assign fall   = fall_q;
endmodule

// File: rtl/dbi_pending.sv
`timescale 1ns/1ps
module dbi_pending
    import debounce_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       stable,
    input  logic       rise,
    input  logic       fall,
    input  logic [2:0] trig,
    input  logic       clr,
    output logic       pending
);
    pend_state_e st_q, st_d;
    logic        hit;

    always_comb begin
        case (trig)
            TRG_RISE: hit = rise;
            TRG_FALL: hit = fall;
            TRG_BOTH: hit = rise | fall;
            TRG_HIGH: hit = stable;
            TRG_LOW:  hit = ~stable;
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PND_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PND_NONE: if (en && hit)         st_d = PND_HELD;   // set
            PND_HELD: if (clr && !(en && hit)) st_d = PND_NONE; // clear
            default:  st_d = PND_NONE;
        endcase
    end

    assign pending = (st_q == PND_HELD);
endmodule

// File: rtl/dbi_regs.sv
`timescale 1ns/1ps
module dbi_regs
    import debounce_irq_pkg::*;
#(
    parameter int N_CH    = 8,
    parameter int TIME_W  = 12,
    parameter int DIV_W   = 16,
    parameter int ADDR_W  = 5,
    parameter int DIV_RST = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [31:0]              wdata,
    input  logic [N_CH-1:0]          stable,
    input  logic [N_CH-1:0]          pend,
    output logic [31:0]              rdata,
    output logic [N_CH-1:0]          en_q,
    output logic [N_CH-1:0]          mask_q,
    output logic [3*N_CH-1:0]        trig_q,
    output logic [DIV_W-1:0]         div_q,
    output logic [N_CH*TIME_W-1:0]   win_q,
    output logic [N_CH-1:0]          clr
);
    localparam int TRIG_W = 3 * N_CH;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            trig_q <= '0;
            div_q  <= DIV_W'(DIV_RST);
            for (int i = 0; i < N_CH; i++) begin
                win_q[i*TIME_W +: TIME_W] <= TIME_W'(1);
            end
        end else if (we) begin
            case (addr)
                ADDR_W'(A_ENABLE): en_q   <= wdata[N_CH-1:0];
                ADDR_W'(A_MASK):   mask_q <= wdata[N_CH-1:0];
                ADDR_W'(A_TRIG):   trig_q <= wdata[TRIG_W-1:0];
                ADDR_W'(A_DIV):    div_q  <= wdata[DIV_W-1:0];
                default: begin
                    for (int i = 0; i < N_CH; i++) begin
                        if (addr == ADDR_W'(A_WIN0 + i)) begin
                            win_q[i*TIME_W +: TIME_W] <= wdata[TIME_W-1:0];
                        end
                    end
                end
            endcase
        end
    end

    assign clr = (we && addr == ADDR_W'(A_CLEAR)) ? wdata[N_CH-1:0] : '0;

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_STABLE): rdata[N_CH-1:0]   = stable;
            ADDR_W'(A_ENABLE): rdata[N_CH-1:0]   = en_q;
            ADDR_W'(A_MASK):   rdata[N_CH-1:0]   = mask_q;
            ADDR_W'(A_TRIG):   rdata[TRIG_W-1:0] = trig_q;
            ADDR_W'(A_RAW):    rdata[N_CH-1:0]   = pend;
            ADDR_W'(A_MSKD):   rdata[N_CH-1:0]   = pend & mask_q;
            ADDR_W'(A_DIV):    rdata[DIV_W-1:0]  = div_q;
            default: begin
                for (int i = 0; i < N_CH; i++) begin
                    if (addr == ADDR_W'(A_WIN0 + i)) begin
                        rdata[TIME_W-1:0] = win_q[i*TIME_W +: TIME_W];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/debounce_irq_ctrl.sv
`timescale 1ns/1ps
module debounce_irq_ctrl
    import debounce_irq_pkg::*;
#(
    parameter int N_CH    = 8,
    parameter int TIME_W  = 12,
    parameter int MAX_WIN = 4000,
    parameter int DIV_W   = 16,
    parameter int ADDR_W  = 5,
    parameter int DIV_RST = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   ext_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    logic                   tick_w;
    logic [N_CH-1:0]        en_q, mask_q, clr_w;
    logic [3*N_CH-1:0]      trig_q;
    logic [DIV_W-1:0]       div_q;
    logic [N_CH*TIME_W-1:0] win_q;
    logic [N_CH-1:0]        stable_w, rise_w, fall_w, status_w;
    logic                   irq_q;

    dbi_regs #(
        .N_CH(N_CH), .TIME_W(TIME_W), .DIV_W(DIV_W),
        .ADDR_W(ADDR_W), .DIV_RST(DIV_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .stable(stable_w), .pend(status_w),
        .rdata(reg_rdata), .en_q(en_q), .mask_q(mask_q),
        .trig_q(trig_q), .div_q(div_q), .win_q(win_q), .clr(clr_w)
    );

    dbi_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick_w)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        dbi_chan #(.TIME_W(TIME_W), .MAX_WIN(MAX_WIN)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(en_q[i]), .tick(tick_w),
            .raw_in(ext_in[i]), .win(win_q[i*TIME_W +: TIME_W]),
            .stable(stable_w[i]), .rise(rise_w[i]), .fall(fall_w[i])
        );
        dbi_pending u_pend (
            .clk(clk), .rst_n(rst_n), .en(en_q[i]), .stable(stable_w[i]),
            .rise(rise_w[i]), .fall(fall_w[i]), .trig(trig_q[3*i +: 3]),
            .clr(clr_w[i]), .pending(status_w[i])
        );
    end

    // registered OR of masked pending bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status_w & mask_q);
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/debounce_irq_chk.sv
`timescale 1ns/1ps
module debounce_irq_chk #(
    parameter int N_CH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic [N_CH-1:0] en,
    input logic [N_CH-1:0] stable,
    input logic [N_CH-1:0] status,
    input logic [N_CH-1:0] clr,
    input logic [N_CH-1:0] mask,
    input logic            irq
);
    AST_IRQ_FOLLOWS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status & mask)))); // R8

    AST_LEVEL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(stable)); // R2

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |=> $stable(stable[i])); // R9

        AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[i] && !status[i]) |=> !status[i]); // R9

        AST_HELD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr[i]) |=> status[i]); // R6
    end
endmodule

bind debounce_irq_ctrl debounce_irq_chk #(.N_CH(N_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .en(en_q),
    .stable(stable_w), .status(status_w), .clr(clr_w),
    .mask(mask_q), .irq(irq)
);

// File: tb/debounce_irq_ctrl_tb.sv
`timescale 1ns/1ps
module debounce_irq_ctrl_tb;
    localparam int N_CH   = 8;
    localparam int ADDR_W = 5;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_IN  = 2'd2;
    localparam logic [1:0] OP_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 57;
    // WR: addr<=data; RD: read addr == expv; IN: ext_in<=data, wait expv; IRQ: irq == data
    localparam vec_t VEC [NV] = '{
        '{OP_WR,  5'd7,  32'd4,      32'd0,      4'd10}, // R10 divisor 4
        '{OP_WR,  5'd8,  32'd2,      32'd0,      4'd4},  // R4 ch0 window 2
        '{OP_WR,  5'd9,  32'd1,      32'd0,      4'd4},
        '{OP_WR,  5'd10, 32'd0,      32'd0,      4'd4},  // R4 ch2 window 0 -> 1
        '{OP_WR,  5'd3,  32'h4688,   32'd0,      4'd5},  // R5 rise,fall,both,high,low
        '{OP_WR,  5'd2,  32'hFF,     32'd0,      4'd8},
        '{OP_WR,  5'd1,  32'h1F,     32'd0,      4'd11},
        '{OP_IN,  5'd0,  32'h00,     32'd4,      4'd5},
        '{OP_RD,  5'd4,  32'd0,      32'h10,     4'd5},  // R5 low level pending
        '{OP_IRQ, 5'd0,  32'd1,      32'd0,      4'd8},  // R8
        '{OP_WR,  5'd6,  32'h10,     32'd0,      4'd7},
        '{OP_IN,  5'd0,  32'h00,     32'd2,      4'd7},
        '{OP_RD,  5'd4,  32'd0,      32'h10,     4'd7},  // R7 re-asserts
        '{OP_WR,  5'd2,  32'hEF,     32'd0,      4'd8},
        '{OP_IN,  5'd0,  32'h00,     32'd2,      4'd8},
        '{OP_IRQ, 5'd0,  32'd0,      32'd0,      4'd8},  // R8 masked off
        '{OP_RD,  5'd5,  32'd0,      32'h00,     4'd8},
        '{OP_IN,  5'd0,  32'h01,     32'd2,      4'd3},  // R3 short glitch
        '{OP_IN,  5'd0,  32'h00,     32'd30,     4'd3},
        '{OP_RD,  5'd0,  32'd0,      32'h00,     4'd3},
        '{OP_IN,  5'd0,  32'h01,     32'd6,      4'd3},  // R3 bounce before window
        '{OP_IN,  5'd0,  32'h00,     32'd30,     4'd3},
        '{OP_RD,  5'd0,  32'd0,      32'h00,     4'd3},
        '{OP_RD,  5'd4,  32'd0,      32'h10,     4'd3},
        '{OP_IN,  5'd0,  32'h07,     32'd30,     4'd2},
        '{OP_RD,  5'd0,  32'd0,      32'h07,     4'd2},  // R2 accepted
        '{OP_RD,  5'd4,  32'd0,      32'h15,     4'd5},  // R5 rise+both
        '{OP_IRQ, 5'd0,  32'd1,      32'd0,      4'd8},
        '{OP_IN,  5'd0,  32'h0F,     32'd30,     4'd5},
        '{OP_RD,  5'd4,  32'd0,      32'h1D,     4'd5},  // R5 high level
        '{OP_WR,  5'd6,  32'h04,     32'd0,      4'd6},
        '{OP_RD,  5'd4,  32'd0,      32'h19,     4'd6},  // R6 cleared
        '{OP_IN,  5'd0,  32'h0B,     32'd30,     4'd5},
        '{OP_RD,  5'd0,  32'd0,      32'h0B,     4'd2},
        '{OP_RD,  5'd4,  32'd0,      32'h1D,     4'd5},  // R5 both on fall
        '{OP_WR,  5'd6,  32'h01,     32'd0,      4'd6},
        '{OP_WR,  5'd6,  32'h00,     32'd0,      4'd6},
        '{OP_RD,  5'd4,  32'd0,      32'h1C,     4'd6},  // R6 zero write inert
        '{OP_IN,  5'd0,  32'h09,     32'd30,     4'd5},
        '{OP_RD,  5'd4,  32'd0,      32'h1E,     4'd5},  // R5 falling
        '{OP_WR,  5'd1,  32'h1E,     32'd0,      4'd9},
        '{OP_IN,  5'd0,  32'h08,     32'd30,     4'd9},
        '{OP_RD,  5'd0,  32'd0,      32'h09,     4'd9},  // R9 frozen
        '{OP_RD,  5'd4,  32'd0,      32'h1E,     4'd9},
        '{OP_WR,  5'd1,  32'h1F,     32'd0,      4'd9},
        '{OP_IN,  5'd0,  32'h08,     32'd30,     4'd9},
        '{OP_RD,  5'd0,  32'd0,      32'h08,     4'd9},  // R9 resumes
        '{OP_IN,  5'd0,  32'h18,     32'd30,     4'd7},
        '{OP_WR,  5'd6,  32'h10,     32'd0,      4'd7},
        '{OP_IN,  5'd0,  32'h18,     32'd2,      4'd7},
        '{OP_RD,  5'd4,  32'd0,      32'h0E,     4'd7},  // R7 clear after level gone
        '{OP_RD,  5'd1,  32'd0,      32'h1F,     4'd11}, // R11
        '{OP_RD,  5'd3,  32'd0,      32'h4688,   4'd11},
        '{OP_RD,  5'd7,  32'd0,      32'd4,      4'd11},
        '{OP_RD,  5'd10, 32'd0,      32'd0,      4'd11},
        '{OP_RD,  5'd6,  32'd0,      32'd0,      4'd6},
        '{OP_RD,  5'd5,  32'd0,      32'h0E,     4'd8}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_CH-1:0]   ext_in = '0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    debounce_irq_ctrl #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DIV_RST(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata, exp, tag);
    endtask

    task automatic drive(input logic [N_CH-1:0] v, input int n);
        @(negedge clk);
        ext_in = v;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            case (VEC[k].op)
                OP_WR:  wr(VEC[k].addr, VEC[k].data);
                OP_RD:  rd(VEC[k].addr, VEC[k].expv, $sformatf("R%0d vec %0d", VEC[k].req, k));
                OP_IN:  drive(VEC[k].data[N_CH-1:0], int'(VEC[k].expv));
                default: begin
                    @(negedge clk);
                    check({31'd0, irq}, VEC[k].data, $sformatf("R%0d vec %0d", VEC[k].req, k));
                end
            endcase
        end

        // R10 tick spacing with divisor 8 and a one-tick window on ch6
        wr(5'd7, 32'd8);
        wr(5'd14, 32'd1);
        wr(5'd1, 32'h5F);
        drive(8'h58, 8);
        rd(5'd0, 32'h18, "R10 early");
        repeat (15) @(negedge clk);
        rd(5'd0, 32'h58, "R10 late");

        // R4 clamp at 4000 ticks, R10 divisor 0 as 1, ch5 window 4095
        wr(5'd7, 32'd0);
        wr(5'd13, 32'd4095);
        wr(5'd1, 32'h7F);
        drive(8'h78, 3900);
        rd(5'd0, 32'h58, "R4 before clamp");
        repeat (150) @(negedge clk);
        rd(5'd0, 32'h78, "R4 clamp R10 zero divisor");

        // R1 reset state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(5'd0, 32'h0, "R1 levels");
        rd(5'd4, 32'h0, "R1 pending");
        rd(5'd1, 32'h0, "R1 enable");
        rd(5'd2, 32'h0, "R1 mask");
        rd(5'd3, 32'h0, "R1 trigger");
        rd(5'd7, 32'd4, "R1 divisor");
        rd(5'd8, 32'd1, "R1 window");
        check({31'd0, irq}, 32'd0, "R1 irq");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule